// File: doc/BRIEF.md
# Masked Vector Gather Sequencer

This block performs an eight-lane gather of 32-bit elements through a single memory read port. A start pulse supplies a base address, a scale, a signed displacement, a 256-bit index operand, a 256-bit mask and the previous destination vector. The block works through the lanes from lane 0 upward. It issues one read for each lane whose mask is active and merges the returned words into the destination. Inactive lanes keep their old contents.

There are two ways to form lane addresses. In indexed mode, every lane carries its own signed 32-bit index. In strided mode, the lowest 32-bit word of the index operand is a stride, and lane j uses stride times j as its index. The mask is retired one lane at a time. A fault therefore stops the operation with the completed lanes cleared and the remaining lanes still pending. Software can fix the fault and issue the same operation again with the returned mask and destination.

Top module: `vgather_seq`

## Requirements
- R1: At start, each 32-bit mask element is replaced by all ones if its bit 31 is set, and by all zeros otherwise. Only this normalised form is used or reported.
- R2: With `strided` low, lane j reads address base_addr + sext(index_vec[32j+31:32j]) * scale + disp.
- R3: With `strided` high, lane j reads address base_addr + (index_vec[31:0] * j) * scale + disp. Lane 0 therefore reads base_addr + disp.
- R4: One read is issued per active lane, strictly in increasing lane order. Inactive lanes issue no read.
- R5: An active lane's destination element takes the returned data. An inactive lane's element keeps its dest_in value.
- R6: Each lane's mask element is cleared once that lane has been handled, whether or not it was active. A run without a fault ends with mask_out all zeros.
- R7: A response with `rsp_fault` set ends the run. `done` is raised with `done_fault` set and `fault_lane` equal to the faulting lane. That lane and all later lanes keep their normalised mask and old destination. Earlier lanes keep their results, and no further read is issued.
- R8: `scale` must be 1, 2, 4 or 8, given as its plain binary value. Any other value ends the run with `done_scale_err` set, no read, mask_out equal to the normalised mask and dest_out equal to dest_in.
- R9: A request holds `req_valid` and `req_addr` stable until `req_ready`. At most one read is outstanding at a time. `done` is a single-cycle pulse.
- R10: Address arithmetic wraps modulo 2^32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an operation (accepted when idle) |
| strided | input | 1 | 1: stride mode, 0: per-lane index mode |
| base_addr | input | 32 | Base address |
| scale | input | 4 | Element scale, legal values 1, 2, 4, 8 |
| disp | input | 32 | Signed displacement |
| index_vec | input | 256 | Per-lane indices, or stride in bits 31:0 |
| mask_in | input | 256 | Per-lane mask, bit 31 of each element significant |
| dest_in | input | 256 | Previous destination vector |
| req_valid | output | 1 | Read request valid |
| req_ready | input | 1 | Memory accepts the request |
| req_addr | output | 32 | Read address |
| rsp_valid | input | 1 | Read response valid |
| rsp_data | input | 32 | Read data |
| rsp_fault | input | 1 | Read faulted |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| done_fault | output | 1 | Completion was caused by a fault |
| done_scale_err | output | 1 | Completion was caused by an illegal scale |
| fault_lane | output | 3 | Lane that faulted |
| mask_out | output | 256 | Mask after the run |
| dest_out | output | 256 | Destination after the run |

## Verification
The sweep covers both modes, every legal scale and mask patterns that include empty, full, alternating and single-ended sets. Random low bits in the mask elements catch a design that tests the whole element instead of bit 31; such a design would fetch lanes that should be skipped. Faults are injected on each lane in turn. A design that cleared the whole mask at once, or kept fetching after a fault, would show the wrong mask_out or an extra request. Negative strides, a base near the top of the address space and illegal scales check sign extension, wrap-around and the rule that rejected runs make no access.

// File: rtl/vgather_seq.sv
module vgather_seq #(
  parameter int LANES = 8,
  parameter int EW    = 32
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      start,
  input  logic                      strided,
  input  logic [EW-1:0]             base_addr,
  input  logic [3:0]                scale,
  input  logic [EW-1:0]             disp,
  input  logic [LANES*EW-1:0]       index_vec,
  input  logic [LANES*EW-1:0]       mask_in,
  input  logic [LANES*EW-1:0]       dest_in,
  output logic                      req_valid,
  input  logic                      req_ready,
  output logic [EW-1:0]             req_addr,
  input  logic                      rsp_valid,
  input  logic [EW-1:0]             rsp_data,
  input  logic                      rsp_fault,
  output logic                      busy,
  output logic                      done,
  output logic                      done_fault,
  output logic                      done_scale_err,
  output logic [$clog2(LANES)-1:0]  fault_lane,
  output logic [LANES*EW-1:0]       mask_out,
  output logic [LANES*EW-1:0]       dest_out
);
  localparam int LW = $clog2(LANES);
  localparam int VW = LANES * EW;
  localparam logic [LW-1:0] LAST = LW'(LANES - 1);

  typedef enum logic [2:0] {S_IDLE, S_SCAN, S_REQ, S_WAIT, S_FIN} st_t;

  st_t            st;
  logic [LW-1:0]  lane;
  logic [EW-1:0]  base_q, disp_q;
  logic [3:0]     scale_q;
  logic           strided_q;
  logic [VW-1:0]  idx_q, mask_q, dst_q;
  logic           fault_q, err_q;
  logic [LW-1:0]  flane_q;

  logic [VW-1:0]  mask_norm;
  logic [EW-1:0]  lane_idx;
  logic           lane_on, scale_ok, last_lane;

  always_comb begin
    for (int i = 0; i < LANES; i++)
      mask_norm[i*EW +: EW] = {EW{mask_in[i*EW + EW - 1]}};
  end

  assign scale_ok  = (scale == 4'd1) || (scale == 4'd2) || (scale == 4'd4) || (scale == 4'd8);
  assign lane_on   = mask_q[lane*EW + EW - 1];
  assign last_lane = (lane == LAST);

  // modulo 2^EW: only the low bits of the full-width sum survive truncation
  assign lane_idx  = strided_q ? idx_q[EW-1:0] * EW'(lane) : idx_q[lane*EW +: EW];
  assign req_addr  = base_q + lane_idx * EW'(scale_q) + disp_q;

  assign req_valid      = (st == S_REQ);
  assign busy           = (st != S_IDLE);
  assign done           = (st == S_FIN);
  assign done_fault     = done && fault_q;
  assign done_scale_err = done && err_q;
  assign fault_lane     = flane_q;
  assign mask_out       = mask_q;
  assign dest_out       = dst_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      lane      <= '0;
      base_q    <= '0;
      disp_q    <= '0;
      scale_q   <= '0;
      strided_q <= 1'b0;
      idx_q     <= '0;
      mask_q    <= '0;
      dst_q     <= '0;
      fault_q   <= 1'b0;
      err_q     <= 1'b0;
      flane_q   <= '0;
    end else begin
      case (st)
        S_IDLE: if (start) begin
          base_q    <= base_addr;
          disp_q    <= disp;
          scale_q   <= scale;
          strided_q <= strided;
          idx_q     <= index_vec;
          mask_q    <= mask_norm;
          dst_q     <= dest_in;
          lane      <= '0;
          fault_q   <= 1'b0;
          flane_q   <= '0;
          err_q     <= !scale_ok;
          st        <= scale_ok ? S_SCAN : S_FIN;
        end
        S_SCAN: if (lane_on) begin
          st <= S_REQ;
        end else begin
          mask_q[lane*EW +: EW] <= '0;
          if (last_lane) st <= S_FIN;
          else lane <= lane + 1'b1;
        end
        S_REQ: if (req_ready) st <= S_WAIT;
        S_WAIT: if (rsp_valid) begin
          if (rsp_fault) begin
            fault_q <= 1'b1;
            flane_q <= lane;
            st      <= S_FIN;
          end else begin
            dst_q[lane*EW +: EW]  <= rsp_data;
            mask_q[lane*EW +: EW] <= '0;
            if (last_lane) st <= S_FIN;
            else begin
              lane <= lane + 1'b1;
              st   <= S_SCAN;
            end
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  logic lower_clear;
  always_comb begin
    lower_clear = 1'b1;
    for (int i = 0; i < LANES; i++)
      if (LW'(i) < lane && mask_q[i*EW +: EW] != '0) lower_clear = 1'b0;
  end

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready |=> req_valid && $stable(req_addr)); // R9
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R9
  AST_RSP_IN_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (st == S_WAIT)); // R9
  AST_ERR_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> !err_q); // R8
  AST_LOWER_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_SCAN || st == S_REQ || st == S_WAIT) |-> lower_clear); // R6
  AST_MASK_SHRINKS: assert property (@(posedge clk) disable iff (!rst_n)
    busy && $past(busy) |-> $countones(mask_q) <= $countones($past(mask_q))); // R6
endmodule

// File: tb/vgather_seq_tb.sv
module vgather_seq_tb;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic         rst_n, start, strided, req_ready, rsp_valid, rsp_fault;
  logic [31:0]  base_addr, disp, rsp_data, req_addr;
  logic [3:0]   scale;
  logic [255:0] index_vec, mask_in, dest_in, mask_out, dest_out;
  logic         req_valid, busy, done, done_fault, done_scale_err;
  logic [2:0]   fault_lane;

  vgather_seq u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .strided(strided),
    .base_addr(base_addr), .scale(scale), .disp(disp), .index_vec(index_vec),
    .mask_in(mask_in), .dest_in(dest_in), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_fault(rsp_fault),
    .busy(busy), .done(done), .done_fault(done_fault), .done_scale_err(done_scale_err),
    .fault_lane(fault_lane), .mask_out(mask_out), .dest_out(dest_out));

  int checks = 0, errors = 0;
  logic [15:0] lfsr = 16'hACE1;
  logic [31:0] exp_addr [8];
  int          exp_cnt, req_seen;
  logic        f_en;
  logic [31:0] f_addr;
  string       areq;

  task automatic chk(input bit ok, input string req, input logic [255:0] act, input logic [255:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  function automatic logic [31:0] mdata(input logic [31:0] a);
    return (a * 32'h9E3779B1) ^ 32'h5A5A0F0F;
  endfunction

  // memory model
  int mst = 0, dly = 0;
  logic        hold_v = 1'b0;
  logic [31:0] hold_a, cur_a;
  always @(negedge clk) begin
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    if (!rst_n) begin
      mst = 0; req_ready = 0; rsp_valid = 0; rsp_fault = 0; rsp_data = 0; hold_v = 0;
    end else case (mst)
      0: if (req_valid) begin
        if (hold_v) chk(req_addr == hold_a, "R9 hold", {224'b0, req_addr}, {224'b0, hold_a});
        if (lfsr[1:0] != 2'b00) begin
          req_ready = 1; cur_a = req_addr; hold_v = 0; mst = 1;
          if (req_seen < exp_cnt)
            chk(req_addr == exp_addr[req_seen], areq, {224'b0, req_addr}, {224'b0, exp_addr[req_seen]});
          else chk(1'b0, "R4 extra request", {224'b0, req_addr}, 256'b0);
          req_seen++;
        end else begin
          hold_v = 1; hold_a = req_addr;
        end
      end
      1: begin req_ready = 0; dly = int'(lfsr[3:2]); mst = 2; end
      2: if (dly == 0) begin
        rsp_valid = 1; rsp_data = mdata(cur_a); rsp_fault = f_en && (cur_a == f_addr); mst = 3;
      end else dly--;
      default: begin rsp_valid = 0; rsp_fault = 0; mst = 0; end
    endcase
  end

  task automatic run_op(input bit sm, input logic [3:0] sc, input logic [31:0] b, input logic [31:0] d,
                        input logic [255:0] iv, input logic [255:0] mv, input logic [255:0] dv,
                        input bit fe, input logic [31:0] fa, input string ar);
    logic [255:0] emask, edst;
    logic [31:0]  a, ix;
    bit faulted = 0, legal;
    logic [2:0] efl = 0;
    int t = 0;
    legal = (sc == 1) || (sc == 2) || (sc == 4) || (sc == 8);
    edst = dv; exp_cnt = 0;
    for (int j = 0; j < 8; j++) emask[j*32 +: 32] = {32{mv[j*32+31]}};
    if (legal) for (int j = 0; j < 8; j++) begin
      if (faulted) continue;
      if (mv[j*32+31]) begin
        ix = sm ? iv[31:0] * 32'(j) : iv[j*32 +: 32];
        a = b + ix * 32'(sc) + d;
        exp_addr[exp_cnt] = a; exp_cnt++;
        if (fe && a == fa) begin faulted = 1; efl = 3'(j); end
        else begin edst[j*32 +: 32] = mdata(a); emask[j*32 +: 32] = 0; end
      end else emask[j*32 +: 32] = 0;
    end
    f_en = fe; f_addr = fa; areq = ar; req_seen = 0;
    strided = sm; scale = sc; base_addr = b; disp = d; index_vec = iv; mask_in = mv; dest_in = dv;
    start = 1;
    @(negedge clk); start = 0;
    while (!done && t < 3000) begin @(negedge clk); t++; end
    if (!done) begin chk(1'b0, "watchdog", 0, 1); return; end
    chk(dest_out == edst, "R5 dest", dest_out, edst);
    chk(mask_out == emask, faulted ? "R7 mask" : (legal ? "R6 mask" : "R1 mask"), mask_out, emask);
    chk(done_fault == faulted, "R7 fault flag", 256'(done_fault), 256'(faulted));
    if (faulted) chk(fault_lane == efl, "R7 lane", 256'(fault_lane), 256'(efl));
    chk(done_scale_err == !legal, "R8 err flag", 256'(done_scale_err), 256'(!legal));
    chk(req_seen == exp_cnt, "R4 request count", 256'(req_seen), 256'(exp_cnt));
    @(negedge clk);
    chk(!done, "R9 done pulse", 256'(done), 0);
  endtask

  function automatic logic [255:0] rvec(input int seed);
    logic [255:0] v;
    for (int j = 0; j < 8; j++) v[j*32 +: 32] = 32'(seed * 97 + j * 1013) * 32'h01000193 ^ 32'(j << 28);
    return v;
  endfunction

  function automatic logic [255:0] mvec(input logic [7:0] p, input int seed);
    logic [255:0] v;
    v = rvec(seed + 7);
    for (int j = 0; j < 8; j++) v[j*32+31] = p[j];
    return v;
  endfunction

  initial begin
    logic [7:0] pats [8] = '{8'hFF, 8'h00, 8'h55, 8'hAA, 8'h81, 8'h7E, 8'h01, 8'h80};
    logic [3:0] scs [4] = '{4'd1, 4'd2, 4'd4, 4'd8};
    logic [3:0] bad [6] = '{4'd0, 4'd3, 4'd5, 4'd7, 4'd9, 4'd15};
    logic [255:0] iv;
    logic [31:0] fa;
    rst_n = 0; start = 0; strided = 0; scale = 4; base_addr = 0; disp = 0;
    index_vec = 0; mask_in = 0; dest_in = 0; f_en = 0; f_addr = 0; exp_cnt = 0; req_seen = 0; areq = "R2";
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(!busy && !done && !req_valid, "reset state", {busy, done, req_valid}, 0);
    chk(mask_out == 0 && dest_out == 0, "reset state vectors", mask_out, 0);

    for (int m = 0; m < 2; m++)
      for (int s = 0; s < 4; s++)
        for (int p = 0; p < 8; p++) begin
          iv = rvec(m * 50 + s * 8 + p);
          if (m == 1) iv[31:0] = (p[0]) ? 32'hFFFF_FFF3 : 32'(p * 3 + 16);
          run_op(m[0], scs[s], 32'h1000_0000 + 32'(p << 8), 32'(s * 4) - 32'd8, iv,
                 mvec(pats[p], p + s), rvec(p + 200), 0, 0, m ? "R3 addr" : "R2 addr");
        end

    // wrap-around of the address sum
    run_op(1, 4, 32'hFFFF_FFF0, 32'h0000_0020, {224'b0, 32'h0000_0040}, mvec(8'hFF, 1), rvec(9), 0, 0, "R10 addr");
    run_op(0, 8, 32'h0000_0010, 32'hFFFF_FF00, rvec(33), mvec(8'hFF, 2), rvec(10), 0, 0, "R10 addr");

    // fault on each lane in turn, all lanes active
    for (int k = 0; k < 8; k++) begin
      iv = '0;
      for (int j = 0; j < 8; j++) iv[j*32 +: 32] = 32'(j * 5 + 1);
      fa = 32'h2000_0000 + 32'(k * 5 + 1) * 32'd4;
      run_op(0, 4, 32'h2000_0000, 0, iv, mvec(8'hFF, k), rvec(k + 300), 1, fa, "R7 addr");
    end
    // fault with sparse mask, strided
    run_op(1, 2, 32'h3000_0000, 32'd4, {224'b0, 32'd8}, mvec(8'hA6, 3), rvec(400), 1,
           32'h3000_0000 + 32'd4 + 32'd5 * 32'd8 * 32'd2, "R7 addr");

    // illegal scales
    for (int e = 0; e < 6; e++)
      run_op(e[0], bad[e], 32'h4000_0000, 0, rvec(e), mvec(8'hC3, e), rvec(e + 500), 0, 0, "R8 addr");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule